// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block turns two encoder inputs, A and B, into a 32-bit position count. One counting engine serves four count sources: full x4 quadrature decoding, pulse plus direction, up-only counting and down-only counting. For the up-only and down-only sources, a rate bit chooses whether A counts on every edge or only on its rising edges. A master run bit gates all counting. The count stays inside a window whose lower bound (floor) and upper bound (ceiling) are both programmable. Stepping past either bound wraps the count to the other bound.

Both encoder inputs pass through two-flop synchronizers. Edges are found by comparing each synchronized sample with the one before it. In quadrature mode, A and B changing in the same sample is a phase fault: it produces a one-cycle flag and does not move the count. Software uses a small register port to set the floor, the ceiling and the control fields, to read back any register, and to load the count directly. A direct load above the ceiling is refused.

Top module: `qpc_top`

## Requirements
- R1: After reset the count reads 0, the floor reads 0, the ceiling reads all ones and the control word reads 0. Register addresses are 0 count, 1 floor, 2 ceiling, 3 control. Control bits other than 15:14, 11 and 3 read back as 0.
- R2: Control bits 15:14 select the count source: 0 quadrature, 1 direction-count, 2 up-count, 3 down-count.
- R3: In quadrature mode every edge of A and every edge of B moves the count by one. The Gray order {A,B} = 00, 10, 11, 01 (A leading B) counts up and the reverse order counts down.
- R4: In quadrature mode, a sample in which A and B both change leaves the count unchanged.
- R5: In direction-count mode only rising edges of A count. B high counts up and B low counts down; the level of B taken is the one in the same sample as the A edge.
- R6: In up-count and down-count modes only A is counted and B has no effect. Control bit 11 set counts both edges of A; bit 11 clear counts rising edges only.
- R7: With control bit 3 (run) clear, the count holds whatever the inputs do.
- R8: A step up when the count is at or above the ceiling loads the floor.
- R9: A step down when the count is at or below the floor loads the ceiling.
- R10: A write to address 0 with a value greater than the ceiling is refused and the count is unchanged. A value at or below the ceiling is loaded at the next clock edge.
- R11: An input change first shows in the count on the third rising clock edge after it is applied: two synchronizer edges, then the count edge.
- R12: `phase_err` is high for exactly one cycle, at the same edge the count would have updated, for each quadrature phase fault seen while run is set. It is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Encoder input A, asynchronous |
| b_in | input | 1 | Encoder input B, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data, valid one cycle after the address |
| pos_count | output | 32 | Current position count |
| phase_err | output | 1 | One-cycle quadrature phase fault flag |

## Verification
The bench sweeps all sixteen transitions between A/B pairs under every source and rate combination, and compares each one against an arithmetic model of direction and step. A decoder with the Gray direction reversed, or one that lets B count in the single-direction modes, gives a count that is off by one or more after the first affected transition. A narrow window (floor 2, ceiling 5) tests both wraps: a counter that wraps to zero instead of the floor, or that uses a strict comparison, lands on a wrong value. The bench also counts the exact edge on which an input change reaches the count, which catches a missing or extra synchronizer stage, and it loads one value just above the ceiling and one at the ceiling to catch an off-by-one in the load check.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam int CNT_W  = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CNT   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLOOR = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CEIL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd3;

  localparam int BIT_SRC_HI = 15;
  localparam int BIT_SRC_LO = 14;
  localparam int BIT_DUAL   = 11;
  localparam int BIT_RUN    = 3;

  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_DIR  = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic dual_edge;
    logic run;
  } cfg_t;

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic b_s,
  input  src_e src,
  input  logic dual_edge,
  output logic step,
  output logic up,
  output logic perr
);

  logic a_d, b_d;
  logic a_ch, b_ch, a_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d <= 1'b0;
      b_d <= 1'b0;
    end else begin
      a_d <= a_s;
      b_d <= b_s;
    end
  end

  assign a_ch   = a_s ^ a_d;
  assign b_ch   = b_s ^ b_d;
  assign a_rise = a_s & ~a_d;

  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    perr = 1'b0;
    unique case (src)
      SRC_QUAD: begin
        perr = a_ch & b_ch;
        step = a_ch ^ b_ch;
        up   = a_ch ? (a_s ^ b_s) : ~(a_s ^ b_s);
      end
      SRC_DIR: begin
        step = a_rise;
        up   = b_s;
      end
      SRC_UP: begin
        step = dual_edge ? a_ch : a_rise;
        up   = 1'b1;
      end
      SRC_DOWN: begin
        step = dual_edge ? a_ch : a_rise;
        up   = 1'b0;
      end
      default: ;
    endcase
  end

  AST_B_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((src == SRC_UP || src == SRC_DOWN) && (a_s == a_d)) |-> !step); // R6

  AST_DIR_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_DIR && step) |-> (a_s && !a_d)); // R5

endmodule

// File: rtl/qpc_regs.sv
module qpc_regs
  import qpc_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  count,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  floor_q,
  output logic [W-1:0]  ceil_q,
  output cfg_t          cfg
);

  logic [W-1:0] ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      floor_q <= '0;
      ceil_q  <= '1;
      cfg     <= '{src: SRC_QUAD, dual_edge: 1'b0, run: 1'b0};
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_FLOOR: floor_q <= wr_data;
        ADDR_CEIL:  ceil_q  <= wr_data;
        ADDR_CTRL: begin
          cfg.src       <= src_e'(wr_data[BIT_SRC_HI:BIT_SRC_LO]);
          cfg.dual_edge <= wr_data[BIT_DUAL];
          cfg.run       <= wr_data[BIT_RUN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[BIT_SRC_HI:BIT_SRC_LO] = cfg.src;
    ctrl_view[BIT_DUAL] = cfg.dual_edge;
    ctrl_view[BIT_RUN]  = cfg.run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_CNT:   rd_data <= count;
        ADDR_FLOOR: rd_data <= floor_q;
        ADDR_CEIL:  rd_data <= ceil_q;
        default:    rd_data <= ctrl_view;
      endcase
    end
  end

endmodule

// File: rtl/qpc_counter.sv
module qpc_counter
  import qpc_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic         up,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] floor_v,
  input  logic [W-1:0] ceil_v,
  output logic [W-1:0] count
);

  logic load_ok;
  assign load_ok = load && (load_val <= ceil_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_ok) begin
      count <= load_val;
    end else if (run && step) begin
      if (up) count <= (count >= ceil_v)  ? floor_v : count + 1'b1;
      else    count <= (count <= floor_v) ? ceil_v  : count - 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count)); // R7

  AST_LOAD_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (load && load_val > ceil_v && !(run && step)) |=> $stable(count)); // R10

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (run && step && up && !load && count >= ceil_v) |=> (count == $past(floor_v))); // R8

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (run && step && !up && !load && count <= floor_v) |=> (count == $past(ceil_v))); // R9

endmodule

// File: rtl/qpc_top.sv
module qpc_top
  import qpc_pkg::*;
#(
  parameter int W          = CNT_W,
  parameter int AW         = ADDR_W,
  parameter int SYNC_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_in,
  input  logic          b_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  pos_count,
  output logic          phase_err
);

  logic [1:0]   ab_s;
  logic         step, up, perr;
  logic         cnt_load;
  logic [W-1:0] floor_q, ceil_q;
  cfg_t         cfg;

  qpc_sync #(.W(2), .STAGES(SYNC_STAGE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({a_in, b_in}),
    .q   (ab_s)
  );

  qpc_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .a_s       (ab_s[1]),
    .b_s       (ab_s[0]),
    .src       (cfg.src),
    .dual_edge (cfg.dual_edge),
    .step      (step),
    .up        (up),
    .perr      (perr)
  );

  qpc_regs #(.W(W), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .count   (pos_count),
    .rd_data (rd_data),
    .floor_q (floor_q),
    .ceil_q  (ceil_q),
    .cfg     (cfg)
  );

  assign cnt_load = wr_en && (wr_addr == ADDR_CNT);

  qpc_counter #(.W(W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .run      (cfg.run),
    .step     (step),
    .up       (up),
    .load     (cnt_load),
    .load_val (wr_data),
    .floor_v  (floor_q),
    .ceil_v   (ceil_q),
    .count    (pos_count)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_err <= 1'b0;
    else     phase_err <= cfg.run && perr;
  end

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cfg.run && perr && !cnt_load) |=> (phase_err && $stable(pos_count))); // R4

  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!cfg.run || !perr) |=> !phase_err); // R12

endmodule

// File: tb/qpc_top_tb.sv
module qpc_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_in = 1'b0, b_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data, pos_count;
  logic        phase_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_cnt = 0, exp_floor = 0, exp_ceil = 32'hFFFF_FFFF;
  logic [1:0]  cur_src = 0;
  logic        cur_dual = 0, cur_run = 0;
  logic [1:0]  prev_ab = 2'b00;

  always #5 clk = ~clk;

  qpc_top u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pos_count(pos_count), .phase_err(phase_err)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] addr, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = addr;
    @(negedge clk);
    check32(tag, rd_data, exp);
  endtask

  task automatic set_ctrl(input logic [1:0] src, input logic dual, input logic run);
    wr_reg(2'd3, (32'(src) << 14) | (32'(dual) << 11) | (32'(run) << 3));
    cur_src = src; cur_dual = dual; cur_run = run;
  endtask

  // Step model from the requirements: returns -1, 0 or +1 and a fault bit.
  function automatic int gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic model(input logic [1:0] p, input logic [1:0] n, output int d, output bit pe);
    bit a_rise, a_any;
    d = 0; pe = 0;
    a_rise = !p[1] && n[1];
    a_any  = p[1] != n[1];
    case (cur_src)
      2'd0: begin
        if (p != n) begin
          if (p[1] != n[1] && p[0] != n[0]) pe = 1;
          else d = (((gray_pos(n) - gray_pos(p)) & 3) == 1) ? 1 : -1;
        end
      end
      2'd1: if (a_rise) d = n[0] ? 1 : -1;
      2'd2: if (cur_dual ? a_any : a_rise) d = 1;
      default: if (cur_dual ? a_any : a_rise) d = -1;
    endcase
  endtask

  task automatic set_ab(input logic a, input logic b, input string tag);
    int d; bit pe;
    model(prev_ab, {a, b}, d, pe);
    if (cur_run) begin
      if (d == 1)       exp_cnt = (exp_cnt >= exp_ceil)  ? exp_floor : exp_cnt + 1;
      else if (d == -1) exp_cnt = (exp_cnt <= exp_floor) ? exp_ceil  : exp_cnt - 1;
    end else pe = 0;
    prev_ab = {a, b};
    @(negedge clk);
    a_in = a; b_in = b;
    repeat (3) @(negedge clk);
    check32(tag, pos_count, exp_cnt);
    check32("R12 phase_err", {31'b0, phase_err}, {31'b0, pe});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values and read-back
    check32("R1 count after reset", pos_count, 32'h0);
    rd_check("R1 read count",   2'd0, 32'h0);
    rd_check("R1 read floor",   2'd1, 32'h0);
    rd_check("R1 read ceiling", 2'd2, 32'hFFFF_FFFF);
    rd_check("R1 read control", 2'd3, 32'h0);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_check("R1 control unused bits", 2'd3, 32'h0000_C808);
    set_ctrl(2'd0, 1'b0, 1'b0);

    // R7 run clear: inputs toggle, count holds
    set_ctrl(2'd2, 1'b1, 1'b0);
    set_ab(1, 0, "R7 hold");
    set_ab(0, 1, "R7 hold");
    set_ab(1, 1, "R7 hold");
    set_ab(0, 0, "R7 hold");

    // R2 R3 R4 R5 R6: every transition for every source and rate
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 2; r++) begin
        set_ctrl(2'(s), 1'(r), 1'b1);
        for (int t = 0; t < 16; t++) begin
          string tg;
          tg = (s == 0) ? "R2/R3/R4 quad" : (s == 1) ? "R2/R5 dir" : "R2/R6 single";
          set_ab(1'(t >> 3), 1'(t >> 2), tg);
          set_ab(1'(t >> 1), 1'(t), tg);
        end
      end
    end

    // R11 latency: third rising edge
    set_ctrl(2'd2, 1'b0, 1'b0);
    set_ab(0, 0, "R11 setup");
    set_ctrl(2'd2, 1'b0, 1'b1);
    begin
      logic [31:0] base;
      base = pos_count;
      @(negedge clk); a_in = 1'b1;
      @(negedge clk); check32("R11 after edge 1", pos_count, base);
      @(negedge clk); check32("R11 after edge 2", pos_count, base);
      @(negedge clk); check32("R11 after edge 3", pos_count, base + 1);
      exp_cnt = base + 1;
      prev_ab = 2'b10;
    end

    // R8 R9 wrap in a narrow window
    set_ctrl(2'd2, 1'b0, 1'b0);
    set_ab(0, 0, "R8 setup");
    wr_reg(2'd1, 32'd2); exp_floor = 2;
    wr_reg(2'd2, 32'd5); exp_ceil = 5;
    wr_reg(2'd0, 32'd4); exp_cnt = 4;
    check32("R10 load within ceiling", pos_count, 32'd4);
    set_ctrl(2'd2, 1'b1, 1'b1);
    set_ab(1, 0, "R8 up to ceiling");
    check32("R8 at ceiling", pos_count, 32'd5);
    set_ab(0, 0, "R8 wrap to floor");
    check32("R8 wrapped", pos_count, 32'd2);
    set_ctrl(2'd3, 1'b1, 1'b1);
    set_ab(1, 0, "R9 wrap to ceiling");
    check32("R9 wrapped", pos_count, 32'd5);
    set_ab(0, 0, "R9 down");

    // R10 load refused above ceiling, accepted at ceiling
    set_ctrl(2'd3, 1'b1, 1'b0);
    wr_reg(2'd0, 32'd6);
    check32("R10 refused load", pos_count, 32'd4);
    wr_reg(2'd0, 32'd5);
    check32("R10 load at ceiling", pos_count, 32'd5);
    rd_check("R10 read count", 2'd0, 32'd5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule